// File: doc/BRIEF.md
# SDRAM Clock Pin Controller

This block decides what appears on the external bus-clock pin that also clocks an SDRAM. Two groups of sources are possible. One is a general bus clock, picked by a two-bit select field from the CPU clock, the bus-unit clock, the PLL clock or the oscillator clock. The other is a dedicated SDRAM clock derived from the CPU clock. A static ratio strap sets whether the SDRAM clock runs at the CPU rate or at half that rate. The bus-unit clock follows the same ratio.

Every source clock arrives as a one-cycle tick on a single fast system clock. Each tick marks one half-period of that source. Inside the block, every source becomes a level that toggles on its own ticks and starts low after reset.

A small 8-bit control register selects the bus clock, switches the pin over to the SDRAM clock, and sets a run-always bit. When the run-always bit is cleared, the pin is parked low while the SDRAM is in self-refresh, and it is floated while the external bus is released to another master. Parking starts and ends only while the generated SDRAM clock is low, so no shortened high pulse ever reaches the pin. The block also brings out the advance strobe of the SDRAM clock, one pulse per SDRAM clock toggle.

Top module: `sdclk_pin_ctrl`

## Requirements
- R1: After reset the register reads 0x08, the pin output-enable is 1 and the pin is low.
- R2: A write stores data bit 7 (SDRAM clock enable), bit 3 (run-always) and bits 1:0 (bus-clock select). All other read bits are 0, and the stored value is visible on rd_data in the cycle after the write strobe.
- R3: With the enable bit at 0, the pin carries the selected bus clock: select 0 gives the CPU clock, 1 the bus-unit clock (same waveform as the SDRAM clock), 2 the PLL clock and 3 the oscillator clock. Each source level toggles once per tick of that source, starting low.
- R4: With the enable bit at 1 and no parking or floating in force, the pin carries the SDRAM clock level.
- R5: With ratio_full at 1, the SDRAM clock toggles on every CPU tick, and sd_tick is high in each cycle in which cpu_tick is high.
- R6: With ratio_full at 0, the SDRAM clock toggles on every second CPU tick, the first toggle coming on the second CPU tick after reset. sd_tick pulses only on those ticks.
- R7: With the run-always bit at 1, self_refresh and bus_released have no effect: the pin keeps toggling and pin_oe stays 1.
- R8: With the enable bit at 1, the run-always bit at 0 and self_refresh at 1, the pin stays low once parking has begun.
- R9: Parking starts and ends only while the SDRAM clock level is low. A request that arrives or leaves while the level is high waits, so the pin stays high, or stays low, until the level falls.
- R10: With the enable bit at 1 and the run-always bit at 0, bus_released drops pin_oe to 0 in the same cycle. This takes priority over self_refresh.
- R11: With the enable bit at 0, self_refresh and bus_released have no effect: pin_oe stays 1 and the pin follows the selected bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | Half-period tick of the CPU clock |
| pll_tick | input | 1 | Half-period tick of the PLL clock |
| osc_tick | input | 1 | Half-period tick of the oscillator clock |
| ratio_full | input | 1 | Ratio strap: 1 selects 1:1, 0 selects 2:1 CPU-to-SDRAM |
| self_refresh | input | 1 | SDRAM is in self-refresh |
| bus_released | input | 1 | External bus is granted to another master |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| sd_tick | output | 1 | SDRAM clock advance strobe |
| pin_out | output | 1 | Value driven onto the bus-clock pin |
| pin_oe | output | 1 | Output-enable of the bus-clock pin |

## Verification
Two events can meet in one cycle: a self-refresh request, with its later removal, and a rising SDRAM clock edge. The bench provokes this by raising and lowering self_refresh while the SDRAM clock is high and then ticking the CPU clock. The pin must hold its level until the clock has fallen, then stay low for the rest of the self-refresh, and only return to toggling after a full low phase. Bus release and self-refresh are also asserted together to show that floating takes priority over parking. Ratio sweeps count pin edges per CPU tick from reset in both strap settings.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W   = 8;
  localparam int EN_BIT  = 7;
  localparam int RUN_BIT = 3;
  localparam int SEL_LSB = 0;
  localparam int SEL_W   = 2;
  localparam int N_SRC   = 3;   // toggled sources: CPU, PLL, oscillator

  typedef enum logic [SEL_W-1:0] {
    SRC_CPU = 2'd0,
    SRC_BUS = 2'd1,
    SRC_PLL = 2'd2,
    SRC_OSC = 2'd3
  } src_sel_e;

  // SDRAM clock advances on a CPU tick: every tick at 1:1, every odd phase at 2:1
  function automatic logic sd_advance(input logic tick, input logic full, input logic phase);
    return tick & (full | phase);
  endfunction

  // parking wanted: SDRAM clock on pin, stop mode, self-refresh, bus still owned
  function automatic logic park_wanted(input logic en, input logic run,
                                       input logic sref, input logic rel);
    return en & ~run & sref & ~rel;
  endfunction

  // floating wanted: SDRAM clock on pin, stop mode, bus handed over
  function automatic logic float_wanted(input logic en, input logic run, input logic rel);
    return en & ~run & rel;
  endfunction

  // read-back image of the control register
  function automatic logic [REG_W-1:0] reg_image(input logic en, input logic run,
                                                 input logic [SEL_W-1:0] sel);
    logic [REG_W-1:0] v;
    v = '0;
    v[EN_BIT] = en;
    v[RUN_BIT] = run;
    v[SEL_LSB +: SEL_W] = sel;
    return v;
  endfunction
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             en,
  output logic             run,
  output src_sel_e         sel,
  output logic [REG_W-1:0] rd_data
);
  logic             en_q;
  logic             run_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b1;
      sel_q <= SRC_CPU;
    end else if (wr_en) begin
      en_q  <= wr_data[EN_BIT];
      run_q <= wr_data[RUN_BIT];
      sel_q <= wr_data[SEL_LSB +: SEL_W];
    end
  end

  assign en      = en_q;
  assign run     = run_q;
  assign sel     = src_sel_e'(sel_q);
  assign rd_data = reg_image(en_q, run_q, sel_q);

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[EN_BIT] == $past(wr_data[EN_BIT])) &&
              (rd_data[RUN_BIT] == $past(wr_data[RUN_BIT])));
endmodule

// File: rtl/sdclk_srcgen.sv
module sdclk_srcgen
  import sdclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_tick,
  input  logic pll_tick,
  input  logic osc_tick,
  input  logic ratio_full,
  output logic cpu_lvl,
  output logic pll_lvl,
  output logic osc_lvl,
  output logic sd_lvl,
  output logic sd_adv
);
  logic [N_SRC-1:0] ticks;
  logic [N_SRC-1:0] lvl_q;
  logic             phase_q;
  logic             sd_q;

  assign ticks = {osc_tick, pll_tick, cpu_tick};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)        lvl_q[g] <= 1'b0;
      else if (ticks[g]) lvl_q[g] <= ~lvl_q[g];
    end
  end

  assign sd_adv = sd_advance(cpu_tick, ratio_full, phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      if (cpu_tick && !ratio_full) phase_q <= ~phase_q;
      if (sd_adv)                  sd_q    <= ~sd_q;
    end
  end

  assign cpu_lvl = lvl_q[0];
  assign pll_lvl = lvl_q[1];
  assign osc_lvl = lvl_q[2];
  assign sd_lvl  = sd_q;

  // R5
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_full && cpu_tick) |=> (sd_lvl != $past(sd_lvl)));

  // R6
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ratio_full && sd_adv) |=> !(sd_adv && !ratio_full));
endmodule

// File: rtl/sdclk_pin_stage.sv
module sdclk_pin_stage
  import sdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     run,
  input  src_sel_e sel,
  input  logic     cpu_lvl,
  input  logic     pll_lvl,
  input  logic     osc_lvl,
  input  logic     sd_lvl,
  input  logic     self_refresh,
  input  logic     bus_released,
  output logic     park_active,
  output logic     pin_out,
  output logic     pin_oe
);
  logic bus_lvl;
  logic gen_lvl;
  logic park_req;
  logic park_q;
  logic float_now;

  always_comb begin
    unique case (sel)
      SRC_CPU: bus_lvl = cpu_lvl;
      SRC_BUS: bus_lvl = sd_lvl;
      SRC_PLL: bus_lvl = pll_lvl;
      default: bus_lvl = osc_lvl;
    endcase
  end

  assign gen_lvl   = en ? sd_lvl : bus_lvl;
  assign park_req  = park_wanted(en, run, self_refresh, bus_released);
  assign float_now = float_wanted(en, run, bus_released);

  // park state only moves while the SDRAM clock is low
  always_ff @(posedge clk) begin
    if (!rst_n)       park_q <= 1'b0;
    else if (!sd_lvl) park_q <= park_req;
  end

  assign park_active = park_q & en;
  assign pin_out     = park_active ? 1'b0 : gen_lvl;
  assign pin_oe      = ~float_now;

  // R9
  park_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_q != $past(park_q)) |-> !$past(sd_lvl));

  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(park_q) && en && run == 1'b0 && self_refresh) |-> park_q);
endmodule

// File: rtl/sdclk_pin_ctrl.sv
module sdclk_pin_ctrl
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_tick,
  input  logic             pll_tick,
  input  logic             osc_tick,
  input  logic             ratio_full,
  input  logic             self_refresh,
  input  logic             bus_released,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sd_tick,
  output logic             pin_out,
  output logic             pin_oe
);
  logic     en;
  logic     run;
  src_sel_e sel;
  logic     cpu_lvl;
  logic     pll_lvl;
  logic     osc_lvl;
  logic     sd_lvl;
  logic     sd_adv;
  logic     park_active;

  sdclk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en(en), .run(run), .sel(sel), .rd_data(rd_data)
  );

  sdclk_srcgen u_src (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .pll_tick(pll_tick),
    .osc_tick(osc_tick), .ratio_full(ratio_full),
    .cpu_lvl(cpu_lvl), .pll_lvl(pll_lvl), .osc_lvl(osc_lvl),
    .sd_lvl(sd_lvl), .sd_adv(sd_adv)
  );

  sdclk_pin_stage u_pin (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .sel(sel),
    .cpu_lvl(cpu_lvl), .pll_lvl(pll_lvl), .osc_lvl(osc_lvl), .sd_lvl(sd_lvl),
    .self_refresh(self_refresh), .bus_released(bus_released),
    .park_active(park_active), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign sd_tick = sd_adv;

  // R10
  float_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> bus_released);

  // R7
  run_no_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(run, 2)) |-> !park_active);
endmodule

// File: tb/sdclk_pin_ctrl_tb.sv
module sdclk_pin_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_tick = 1'b0, pll_tick = 1'b0, osc_tick = 1'b0;
  logic       ratio_full = 1'b1, self_refresh = 1'b0, bus_released = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sd_tick, pin_out, pin_oe;

  int checks = 0, errors = 0;
  int cpu_n = 0, pll_n = 0, osc_n = 0, sd_n = 0;
  bit phase = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  sdclk_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .pll_tick(pll_tick),
    .osc_tick(osc_tick), .ratio_full(ratio_full), .self_refresh(self_refresh),
    .bus_released(bus_released), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sd_tick(sd_tick), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_tick = 0; pll_tick = 0; osc_tick = 0;
    self_refresh = 0; bus_released = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cpu_n = 0; pll_n = 0; osc_n = 0; sd_n = 0; phase = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // one CPU tick; checks the advance strobe and updates the arithmetic model
  task automatic tick_cpu(input string req);
    bit adv;
    @(negedge clk); cpu_tick = 1'b1;
    adv = ratio_full | phase;
    #1 check(sd_tick == adv, req, sd_tick, adv);
    @(negedge clk); cpu_tick = 1'b0;
    cpu_n++;
    if (adv) sd_n++;
    if (!ratio_full) phase = ~phase;
  endtask

  task automatic tick_pll();
    @(negedge clk); pll_tick = 1'b1; @(negedge clk); pll_tick = 1'b0; pll_n++;
  endtask

  task automatic tick_osc();
    @(negedge clk); osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0; osc_n++;
  endtask

  task automatic sweep(input int n, input int exp_edges, input string req);
    int edges = 0;
    for (int i = 0; i < n; i++) begin
      logic prev;
      prev = pin_out;
      tick_cpu(req);
      if (pin_out != prev) edges++;
      check(pin_out == sd_n[0], req, pin_out, sd_n[0]);
    end
    check(edges == exp_edges, req, edges, exp_edges);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ratio_full = 1'b1;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(rd_data == 8'h08, "R1", rd_data, 8'h08);
    check(pin_oe == 1'b1, "R1", pin_oe, 1);
    check(pin_out == 1'b0, "R1", pin_out, 0);

    // R3 CPU clock on the pin
    for (int i = 0; i < 5; i++) begin
      tick_cpu("R3");
      check(pin_out == cpu_n[0], "R3", pin_out, cpu_n[0]);
    end

    // R11 stop mode but SDRAM clock off: status inputs ignored
    write_reg(8'h00);
    self_refresh = 1'b1; bus_released = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick_cpu("R11");
      check(pin_oe == 1'b1, "R11", pin_oe, 1);
      check(pin_out == cpu_n[0], "R11", pin_out, cpu_n[0]);
    end
    self_refresh = 1'b0; bus_released = 1'b0;

    // R2 readback masks
    write_reg(8'hFF); @(negedge clk);
    check(rd_data == 8'h8B, "R2", rd_data, 8'h8B);
    write_reg(8'h76); @(negedge clk);
    check(rd_data == 8'h02, "R2", rd_data, 8'h02);

    // R3 PLL, oscillator and bus-unit selections
    write_reg(8'h0A);
    for (int i = 0; i < 3; i++) begin
      tick_pll();
      check(pin_out == pll_n[0], "R3", pin_out, pll_n[0]);
    end
    write_reg(8'h0B);
    for (int i = 0; i < 3; i++) begin
      tick_osc();
      check(pin_out == osc_n[0], "R3", pin_out, osc_n[0]);
    end
    write_reg(8'h09);
    for (int i = 0; i < 3; i++) begin
      tick_cpu("R3");
      check(pin_out == sd_n[0], "R3", pin_out, sd_n[0]);
    end

    // R4 / R5 SDRAM clock at 1:1
    write_reg(8'h88);
    sweep(16, 16, "R5");
    check(pin_out == sd_n[0], "R4", pin_out, sd_n[0]);

    // R7 run-always ignores status
    self_refresh = 1'b1; bus_released = 1'b1;
    sweep(6, 6, "R7");
    check(pin_oe == 1'b1, "R7", pin_oe, 1);
    self_refresh = 1'b0; bus_released = 1'b0;

    // R9 / R8 park timing against the SDRAM clock
    write_reg(8'h80);
    if (sd_n[0] == 1'b0) tick_cpu("R9");
    self_refresh = 1'b1;
    repeat (3) @(negedge clk);
    check(pin_out == 1'b1, "R9", pin_out, 1);
    tick_cpu("R9");
    for (int i = 0; i < 5; i++) begin
      tick_cpu("R8");
      check(pin_out == 1'b0, "R8", pin_out, 0);
    end
    if (sd_n[0] == 1'b0) tick_cpu("R8");
    self_refresh = 1'b0;
    repeat (2) @(negedge clk);
    check(pin_out == 1'b0, "R9", pin_out, 0);
    tick_cpu("R9");
    check(pin_out == 1'b0, "R9", pin_out, 0);
    tick_cpu("R9");
    check(pin_out == sd_n[0], "R9", pin_out, sd_n[0]);

    // R10 float and its priority over parking
    @(negedge clk); bus_released = 1'b1;
    #1 check(pin_oe == 1'b0, "R10", pin_oe, 0);
    self_refresh = 1'b1;
    repeat (3) @(negedge clk);
    check(pin_oe == 1'b0, "R10", pin_oe, 0);
    self_refresh = 1'b0; bus_released = 1'b0;
    #1 check(pin_oe == 1'b1, "R10", pin_oe, 1);

    // R6 half rate from reset
    ratio_full = 1'b0;
    do_reset();
    write_reg(8'h88);
    tick_cpu("R6");
    check(pin_out == 1'b0, "R6", pin_out, 0);
    tick_cpu("R6");
    check(pin_out == 1'b1, "R6", pin_out, 1);
    sweep(16, 8, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule